// File: doc/BRIEF.md
# Scan Compare Unit for a Shared Test Bus

This block sits on every addressable board of a parallel test bus. A central controller broadcasts expected scan data and a mask bit on each shift clock, and each board checks its own scan-out locally. Captured data never travels back to the controller. In five-wire operation the expected bit arrives on the board's data-out pin, which is turned around to act as an input, and the mask bit arrives on the reset pin. The TAP logic around this block decodes those pins and presents them as plain inputs.

Bits are compared only while the TAP is shifting (data or instruction path) and comparison is enabled. The first unmasked mismatch sets a sticky fail flag and raises a brake. The brake freezes the board's selected local scan paths, so that the diagnostic state stays intact. The controller can also raise the brake at the end of a test. A 16-bit counter records how many shift cycles were compared before the first failure. The fail flag and that count form a result word, which an ordinary TAP data-register scan can capture and shift out.

Top module: `scu_top`

## Requirements
- R1: After asynchronous reset, `fail`, `brake` and `rd_tdo` are 0 and the shift count is 0.
- R2: On a rising clock edge where `tap_shift`=1, `cmp_en`=1, `mask_bit`=0 and `scan_bit`≠`exp_bit`, `fail` becomes 1 after that edge.
- R3: A bit with `mask_bit`=1 never sets `fail`, whatever `scan_bit` and `exp_bit` are.
- R4: No comparison takes place on an edge where `tap_shift`=0 or `cmp_en`=0. Such edges leave `fail` and the count unchanged.
- R5: Once set, `fail` stays 1 until `tap_tlr` or `cmp_clr` is sampled high.
- R6: `brake` rises at the same edge that sets `fail`, so it is in force from the clock cycle after the miscompare. A sampled `stop_req` also sets `brake` without setting `fail`.
- R7: `tap_tlr` or `cmp_clr` sampled high clears `fail`, `brake` and the count. A clear takes priority over a miscompare sampled on the same edge.
- R8: The count increments on each compared edge that does not fail. It holds the number of compared cycles before the first failure, and it saturates at 65535.
- R9: When `rd_sel`=1 and `rd_cap`=1, the result word {count, fail} (fail in bit 0, count in bits 16:1) is loaded. With `rd_sel`=1 and `rd_shift`=1, the word shifts toward bit 0 and `rd_tdi` enters bit 16. `rd_tdo` always shows bit 0.
- R10: While `brake` is 1, no comparison takes place. A miscompare has no effect, and the count is frozen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tap_tlr | input | 1 | TAP is in Test-Logic-Reset |
| tap_shift | input | 1 | TAP is in Shift-DR or Shift-IR |
| cmp_en | input | 1 | Comparison enabled by configuration |
| cmp_clr | input | 1 | Explicit clear from the configuration register |
| stop_req | input | 1 | End-of-test brake request |
| scan_bit | input | 1 | Local scan-path output bit |
| exp_bit | input | 1 | Broadcast expected bit |
| mask_bit | input | 1 | Broadcast mask bit, 1 = ignore |
| rd_sel | input | 1 | Result register selected as data register |
| rd_cap | input | 1 | Capture into result register |
| rd_shift | input | 1 | Shift result register |
| rd_tdi | input | 1 | Serial input to result register |
| fail | output | 1 | Sticky fail flag |
| brake | output | 1 | Freeze local scan paths |
| rd_tdo | output | 1 | Serial output of result register |

## Verification
A clear and a miscompare can arrive on the same edge. So can a brake request and a miscompare. The bench drives an unmasked mismatch while `cmp_clr` is high and expects `fail` and `brake` to read 0 after the edge, because the clear wins. It then raises `stop_req` alone and presents a mismatch on the next edge, and expects `brake`=1 with `fail` still 0, because the brake closes comparison. A readout of the result word then confirms that the count did not move across either event.

// File: rtl/scu_pkg.sv
package scu_pkg;
    // outcome of one compare slot
    typedef enum logic [1:0] {
        CMP_IDLE  = 2'd0,
        CMP_MATCH = 2'd1,
        CMP_MISS  = 2'd2
    } cmp_res_e;
endpackage

// File: rtl/scu_compare.sv
module scu_compare
    import scu_pkg::*;
(
    input  logic     active,
    input  logic     scan_bit,
    input  logic     exp_bit,
    input  logic     mask_bit,
    output cmp_res_e res
);
    always_comb begin
        if (!active)
            res = CMP_IDLE;
        else if (!mask_bit && (scan_bit != exp_bit))
            res = CMP_MISS;
        else
            res = CMP_MATCH;
    end
endmodule

// File: rtl/scu_track.sv
module scu_track
    import scu_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tlr,
    input  logic             clr,
    input  logic             stop_req,
    input  cmp_res_e         res,
    output logic             fail,
    output logic             brake,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic             fail;
        logic             brake;
        logic [CNT_W-1:0] cnt;
    } track_t;

    track_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (tlr || clr) begin
            s_d = '0;
        end else begin
            if (stop_req)
                s_d.brake = 1'b1;
            case (res)
                CMP_MISS: begin
                    s_d.fail  = 1'b1;
                    s_d.brake = 1'b1;
                end
                CMP_MATCH: begin
                    if (s_q.cnt != CNT_MAX)
                        s_d.cnt = s_q.cnt + 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign fail  = s_q.fail;
    assign brake = s_q.brake;
    assign cnt   = s_q.cnt;

    // R5
    fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.fail && !tlr && !clr) |=> s_q.fail);
    // R6
    brake_with_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.fail) |-> s_q.brake);
    // R7
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tlr || clr) |=> (!s_q.fail && !s_q.brake && s_q.cnt == '0));
    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res == CMP_IDLE && !tlr && !clr) |=> ($stable(s_q.fail) && $stable(s_q.cnt)));
    // R8
    cnt_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt == CNT_MAX && !tlr && !clr) |=> s_q.cnt == CNT_MAX);
endmodule

// File: rtl/scu_result.sv
module scu_result #(
    parameter int W = 17
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sel,
    input  logic         cap,
    input  logic         shift,
    input  logic         tdi,
    input  logic [W-1:0] word,
    output logic         tdo
);
    typedef struct packed {
        logic [W-1:0] sh;
    } res_t;

    res_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (sel && cap)
            r_d.sh = word;
        else if (sel && shift)
            r_d.sh = {tdi, r_q.sh[W-1:1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign tdo = r_q.sh[0];

    // R9
    capture_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && cap) |=> (r_q.sh == $past(word)));
    // R9
    shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && shift && !cap) |=> (r_q.sh[W-1] == $past(tdi)));
endmodule

// File: rtl/scu_top.sv
module scu_top
    import scu_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tap_tlr,
    input  logic tap_shift,
    input  logic cmp_en,
    input  logic cmp_clr,
    input  logic stop_req,
    input  logic scan_bit,
    input  logic exp_bit,
    input  logic mask_bit,
    input  logic rd_sel,
    input  logic rd_cap,
    input  logic rd_shift,
    input  logic rd_tdi,
    output logic fail,
    output logic brake,
    output logic rd_tdo
);
    localparam int RES_W = CNT_W + 1;

    cmp_res_e         res;
    logic             active;
    logic [CNT_W-1:0] cnt;

    assign active = tap_shift && cmp_en && !brake;

    scu_compare u_cmp (
        .active   (active),
        .scan_bit (scan_bit),
        .exp_bit  (exp_bit),
        .mask_bit (mask_bit),
        .res      (res)
    );

    scu_track #(.CNT_W(CNT_W)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .tlr      (tap_tlr),
        .clr      (cmp_clr),
        .stop_req (stop_req),
        .res      (res),
        .fail     (fail),
        .brake    (brake),
        .cnt      (cnt)
    );

    scu_result #(.W(RES_W)) u_res (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (rd_sel),
        .cap   (rd_cap),
        .shift (rd_shift),
        .tdi   (rd_tdi),
        .word  ({cnt, fail}),
        .tdo   (rd_tdo)
    );

    // R10
    brake_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (brake && !tap_tlr && !cmp_clr) |=> ($stable(cnt) && $stable(fail)));
    // R3
    mask_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fail && mask_bit && !stop_req) |=> !fail);
endmodule

// File: tb/scu_top_tb.sv
`timescale 1ns/1ps
module scu_top_tb;
    localparam int W = 17;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tap_tlr = 0, tap_shift = 0, cmp_en = 0, cmp_clr = 0, stop_req = 0;
    logic scan_bit = 0, exp_bit = 0, mask_bit = 0;
    logic rd_sel = 0, rd_cap = 0, rd_shift = 0, rd_tdi = 0;
    logic fail, brake, rd_tdo;

    int n_chk = 0, n_bad = 0, cyc = 0;

    always #10 clk = ~clk;

    scu_top u_dut (.*);

    // {shift, en, scan, exp, mask, expected fail after edge}
    localparam int NV = 8;
    localparam logic [5:0] VEC [NV] = '{
        6'b11000_0,  // match
        6'b11110_0,  // match
        6'b11101_0,  // R3 masked mismatch
        6'b01100_0,  // R4 not shifting
        6'b10010_0,  // R4 compare disabled
        6'b11010_1,  // R2 unmasked mismatch
        6'b11000_1,  // R5 sticky
        6'b00000_1
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic read_result(output logic [W-1:0] w);
        rd_sel = 1; rd_cap = 1; step(); rd_cap = 0;
        for (int i = 0; i < W; i++) begin
            w[i] = rd_tdo;
            rd_shift = 1; step();
        end
        rd_shift = 0; rd_sel = 0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=<190000", cyc);
            finish_run();
        end
    end

    initial begin
        logic [W-1:0] w;
        #25;
        // R1 reset state
        chk("R1 fail", fail, 0);
        chk("R1 brake", brake, 0);
        chk("R1 tdo", rd_tdo, 0);
        rst_n = 1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            {tap_shift, cmp_en, scan_bit, exp_bit, mask_bit} = VEC[i][5:1];
            step();
            chk($sformatf("R2/R3/R4/R5 vec%0d fail", i), fail, VEC[i][0]);
            chk($sformatf("R6 vec%0d brake", i), brake, VEC[i][0]);
        end
        // R8 R9 R10: three compared cycles before the miss, frozen after
        read_result(w);
        chk("R9 fail bit", w[0], 1);
        chk("R8 count", w[16:1], 3);

        // R9 serial input reaches bit 0 after W shifts
        rd_sel = 1; rd_tdi = 1;
        for (int i = 0; i < W; i++) begin rd_shift = 1; step(); end
        rd_shift = 0; rd_sel = 0; rd_tdi = 0;
        chk("R9 tdi path", rd_tdo, 1);

        // R7 explicit clear
        cmp_clr = 1; step(); cmp_clr = 0;
        chk("R7 clr fail", fail, 0);
        chk("R7 clr brake", brake, 0);
        read_result(w);
        chk("R7 clr count", w[16:1], 0);

        // R6 brake timing: not before the edge, set after it
        tap_shift = 1; cmp_en = 1; scan_bit = 1; exp_bit = 0; mask_bit = 0;
        #5;
        chk("R6 brake before edge", brake, 0);
        step();
        chk("R6 brake after edge", brake, 1);
        tap_shift = 0;
        tap_tlr = 1; step(); tap_tlr = 0;
        chk("R7 tlr fail", fail, 0);
        chk("R7 tlr brake", brake, 0);

        // R7 clear beats a same-edge miscompare
        tap_shift = 1; cmp_clr = 1; step(); cmp_clr = 0; tap_shift = 0;
        chk("R7 clear priority fail", fail, 0);
        chk("R7 clear priority brake", brake, 0);

        // R6 stop request alone; R10 brake blocks compare
        tap_shift = 1; exp_bit = 1; scan_bit = 1;
        step();                       // one matching compare, count=1
        stop_req = 1; tap_shift = 0; step(); stop_req = 0;
        chk("R6 stop brake", brake, 1);
        chk("R6 stop no fail", fail, 0);
        tap_shift = 1; scan_bit = 0; step(); step(); tap_shift = 0;
        chk("R10 miss under brake", fail, 0);
        read_result(w);
        chk("R10 count frozen", w[16:1], 1);
        cmp_clr = 1; step(); cmp_clr = 0;

        // R8 saturation
        tap_shift = 1; scan_bit = 1; exp_bit = 1;
        for (int i = 0; i < 66000; i++) step();
        tap_shift = 0;
        read_result(w);
        chk("R8 saturated count", w[16:1], 65535);
        chk("R8 no fail", w[0], 0);

        finish_run();
    end
endmodule